// File: doc/BRIEF.md
# Latched Real-Time Clock Controller

This block extends a cartridge bank controller with a running time-of-day counter and a frozen copy of it that the CPU reads. The live counter holds seconds, minutes, hours and a 9-bit day count, plus a halt bit and a sticky day-overflow flag. It advances once per second. The second is derived from a sub-second pulse input through a prescaler that divides by `DIV`.

The CPU reaches the block through plain byte writes on a 16-bit address bus.
- Writes in the 0x4000–0x5FFF region choose what the 0xA000–0xBFFF window shows: a RAM bank or one of five clock registers.
- Writes in the 0x6000–0x7FFF region run a two-step latch handshake that copies the live counter into the snapshot.
- Writes in the 0xA000–0xBFFF window load the selected live register, but only while clock access is on.

The block outputs the RAM bank number, a flag saying the window currently maps to a clock register, and read data for the selected snapshot register.

Top module: `rtc_latch_ctrl`

## Requirements
- R1: After reset all clock registers and snapshots are zero, the latch flag is clear, clock access is off, the bank is 0 and register 0 is selected.
- R2: A write to 0x4000–0x5FFF (address bits [15:13] = 3'b010) with a value below 4 sets the RAM bank to that value and turns clock access off.
- R3: A write to that region with a value from 0x08 to 0x0C selects clock register (value−8) and turns clock access on. Any other value changes neither the bank, the selection nor the access flag.
- R4: Read data shows the selected snapshot register, and unused bits read as 1:
  - register 0 is {2'b11, seconds};
  - register 1 is {2'b11, minutes};
  - register 2 is {3'b111, hours};
  - register 3 is day bits [7:0];
  - register 4 is {overflow, halt, 5'b11111, day bit 8}.
- R5: Every `DIV` sub-second pulses the seconds advance by one. Seconds wrap 59→0 and carry into minutes. Minutes wrap 59→0 and carry into hours. Hours wrap 23→0 and carry into the day count.
- R6: When the 9-bit day count passes 511 it wraps to 0 and the overflow bit (register 4 bit 7) is set. The bit stays set until a window write to register 4 clears it.
- R7: A write to 0x6000–0x7FFF (bits [15:13] = 3'b011) behaves as follows:
  - a value of 1 copies the live counter into the snapshot and sets the latch flag, but only when the flag is clear;
  - a value of 0 clears the flag, but only when it is set;
  - all other writes leave the flag and the snapshot unchanged.
- R8: While the halt bit (register 4 bit 6) is 1, sub-second pulses are ignored: neither the seconds nor the prescaler move.
- R9: A write to 0xA000–0xBFFF (bits [15:13] = 3'b101) while clock access is on loads the selected live register; register 4 takes bits 7, 6 and 0. A seconds write also clears the prescaler. Window writes while clock access is off change no clock state.
- R10: The snapshot does not follow the live counter between latch events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_pulse | input | 1 | Sub-second enable pulse, `DIV` per second |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| ram_bank | output | 2 | Selected RAM bank |
| clk_map | output | 1 | Window maps to a clock register |
| rd_data | output | 8 | Selected snapshot register, unused bits 1 |

## Verification
The hardest state to reach from the ports is a full carry from seconds through minutes and hours into a day count of 511. That is what sets the overflow flag; counting there naturally would take hundreds of simulated days. The stimulus instead uses the clock-register window to preload 59 s, 59 min, 23 h and day 511. It writes seconds last, so the prescaler is cleared, and then sends exactly `DIV` pulses. Every live value is then observed through the latch handshake: a 0 followed by a 1 on the latch region, then a register select.

// File: rtl/rtc_latch_ctrl.sv
`timescale 1ns/1ps
module rtc_latch_ctrl #(
  parameter int DIV = 32768
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sub_pulse,
  input  logic        wr_en,
  input  logic [15:0] wr_addr,
  input  logic [7:0]  wr_data,
  output logic [1:0]  ram_bank,
  output logic        clk_map,
  output logic [7:0]  rd_data
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(DIV - 1);

  logic [5:0] sec, min, l_sec, l_min;
  logic [4:0] hr, l_hr;
  logic [8:0] day, l_day;
  logic       halt, ovf, l_halt, l_ovf, lflag;
  logic [2:0] sel;
  logic [PW-1:0] pre;

  wire in_sel = wr_en && (wr_addr[15:13] == 3'b010);
  wire in_lat = wr_en && (wr_addr[15:13] == 3'b011);
  wire in_win = wr_en && (wr_addr[15:13] == 3'b101) && clk_map;
  wire run    = sub_pulse && !halt;
  wire step   = run && (pre == PRE_LAST);

  wire c_min = step && (sec >= 6'd59);
  wire c_hr  = c_min && (min >= 6'd59);
  wire c_day = c_hr && (hr >= 5'd23);

  logic [5:0] n_sec, n_min;
  logic [4:0] n_hr;
  logic [8:0] n_day;
  logic       n_ovf;

  always_comb begin
    n_sec = step ? ((sec >= 6'd59) ? 6'd0 : sec + 6'd1) : sec;
    n_min = c_min ? ((min >= 6'd59) ? 6'd0 : min + 6'd1) : min;
    n_hr  = c_hr ? ((hr >= 5'd23) ? 5'd0 : hr + 5'd1) : hr;
    n_day = day + {8'd0, c_day};
    n_ovf = ovf | (c_day && (&day));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec <= '0; min <= '0; hr <= '0; day <= '0; halt <= 1'b0; ovf <= 1'b0;
      pre <= '0;
    end else begin
      sec <= n_sec; min <= n_min; hr <= n_hr; day <= n_day; ovf <= n_ovf;
      if (in_win && sel == 3'd0) pre <= '0;
      else if (run) pre <= (pre == PRE_LAST) ? '0 : pre + 1'b1;
      if (in_win) begin
        case (sel)
          3'd0: sec <= wr_data[5:0];
          3'd1: min <= wr_data[5:0];
          3'd2: hr  <= wr_data[4:0];
          3'd3: day <= {n_day[8], wr_data};
          3'd4: begin
            day  <= {wr_data[0], n_day[7:0]};
            halt <= wr_data[6];
            ovf  <= wr_data[7];
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lflag <= 1'b0;
      l_sec <= '0; l_min <= '0; l_hr <= '0; l_day <= '0; l_halt <= 1'b0; l_ovf <= 1'b0;
    end else if (in_lat) begin
      if (lflag && wr_data == 8'd0) lflag <= 1'b0;
      else if (!lflag && wr_data == 8'd1) begin
        lflag <= 1'b1;
        l_sec <= sec; l_min <= min; l_hr <= hr; l_day <= day;
        l_halt <= halt; l_ovf <= ovf;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_bank <= '0; clk_map <= 1'b0; sel <= '0;
    end else if (in_sel) begin
      if (wr_data < 8'd4) begin
        ram_bank <= wr_data[1:0];
        clk_map  <= 1'b0;
      end else if (wr_data >= 8'h08 && wr_data <= 8'h0C) begin
        sel     <= 3'(wr_data - 8'h08);
        clk_map <= 1'b1;
      end
    end
  end

  always_comb begin
    case (sel)
      3'd0:    rd_data = {2'b11, l_sec};
      3'd1:    rd_data = {2'b11, l_min};
      3'd2:    rd_data = {3'b111, l_hr};
      3'd3:    rd_data = l_day[7:0];
      3'd4:    rd_data = {l_ovf, l_halt, 5'b11111, l_day[8]};
      default: rd_data = 8'hFF;
    endcase
  end
endmodule

// File: rtl/rtc_latch_ctrl_chk.sv
`timescale 1ns/1ps
module rtc_latch_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_addr,
  input logic [7:0]  wr_data,
  input logic [1:0]  ram_bank,
  input logic        clk_map,
  input logic [5:0]  sec,
  input logic [5:0]  l_sec,
  input logic        halt,
  input logic        ovf,
  input logic        lflag
);
  wire sel_w = wr_en && wr_addr[15:13] == 3'b010;
  wire lat_w = wr_en && wr_addr[15:13] == 3'b011;
  wire win_w = wr_en && wr_addr[15:13] == 3'b101 && clk_map;

  // R2
  bank_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_w && wr_data < 8'd4 |=> ram_bank == $past(wr_data[1:0]) && !clk_map);

  // R3
  clock_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_w && wr_data >= 8'h08 && wr_data <= 8'h0C |=> clk_map);

  // R6
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !win_w |=> ovf);

  // R7
  latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lflag) |-> $past(lat_w && wr_data == 8'd1));

  // R10
  snapshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lat_w && wr_data == 8'd1) |=> $stable(l_sec));

  // R8
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt && !win_w |=> $stable(sec));
endmodule

bind rtc_latch_ctrl rtc_latch_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .ram_bank(ram_bank), .clk_map(clk_map), .sec(sec), .l_sec(l_sec),
  .halt(halt), .ovf(ovf), .lflag(lflag)
);

// File: tb/test_rtc_latch_ctrl.sv
`timescale 1ns/1ps
module test_rtc_latch_ctrl;
  localparam int DIV = 4;
  logic clk = 1'b0, rst_n = 1'b0, sub_pulse = 1'b0, wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  ram_bank;
  logic        clk_map;
  logic [7:0]  rd_data;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  rtc_latch_ctrl #(.DIV(DIV)) i_rtc_latch_ctrl (
    .clk(clk), .rst_n(rst_n), .sub_pulse(sub_pulse), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .ram_bank(ram_bank),
    .clk_map(clk_map), .rd_data(rd_data));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulses(int n);
    @(negedge clk); sub_pulse = 1'b1;
    repeat (n) @(negedge clk);
    sub_pulse = 1'b0;
  endtask

  task automatic snap();
    wr(16'h6000, 8'h00); wr(16'h6000, 8'h01);
  endtask

  task automatic rd(int idx, string req, logic [7:0] exp);
    wr(16'h4000, 8'(8 + idx));
    chk(req, rd_data, exp);
  endtask

  task automatic setreg(int idx, logic [7:0] v);
    wr(16'h4000, 8'(8 + idx)); wr(16'hA000, v);
  endtask

  task automatic t_reset();
    chk("R1 bank", {6'd0, ram_bank}, 8'h00);
    chk("R1 map", {7'd0, clk_map}, 8'h00);
    chk("R1 rd", rd_data, 8'hC0);
  endtask

  task automatic t_select();
    wr(16'h4000, 8'h03);
    chk("R2 bank", {6'd0, ram_bank}, 8'h03);
    chk("R2 map", {7'd0, clk_map}, 8'h00);
    wr(16'h4000, 8'h0A);
    chk("R3 map", {7'd0, clk_map}, 8'h01);
    chk("R3 bank kept", {6'd0, ram_bank}, 8'h03);
    chk("R4 reg2", rd_data, 8'hE0);
    wr(16'h4000, 8'h05);
    chk("R3 ignored map", {7'd0, clk_map}, 8'h01);
    wr(16'h5000, 8'h0D);
    chk("R3 ignored rd", rd_data, 8'hE0);
    wr(16'h4000, 8'h0C);
    chk("R4 reg4", rd_data, 8'h3E);
    wr(16'h5FFF, 8'h01);
    chk("R2 bank1", {6'd0, ram_bank}, 8'h01);
    chk("R2 map off", {7'd0, clk_map}, 8'h00);
  endtask

  task automatic t_window_off();
    wr(16'hA000, 8'h15);
    snap();
    rd(0, "R9 window ignored", 8'hC0);
  endtask

  task automatic t_count();
    setreg(1, 8'd5); setreg(0, 8'd59);
    pulses(DIV); snap();
    rd(0, "R5 sec wrap", 8'hC0);
    rd(1, "R5 min carry", 8'hC6);
    pulses(DIV - 1); snap();
    rd(0, "R5 no step early", 8'hC0);
    pulses(1); snap();
    rd(0, "R5 step", 8'hC1);
  endtask

  task automatic t_prescale_clear();
    pulses(2); setreg(0, 8'd10);
    pulses(DIV - 1); snap();
    rd(0, "R9 prescaler cleared", 8'hCA);
    pulses(1); snap();
    rd(0, "R9 prescaler step", 8'hCB);
  endtask

  task automatic t_day_chain();
    setreg(3, 8'd7); setreg(4, 8'h00); setreg(2, 8'd23); setreg(1, 8'd59); setreg(0, 8'd59);
    pulses(DIV); snap();
    rd(0, "R5 chain sec", 8'hC0);
    rd(1, "R5 chain min", 8'hC0);
    rd(2, "R5 chain hr", 8'hE0);
    rd(3, "R5 chain day", 8'h08);
    rd(4, "R5 chain reg4", 8'h3E);
  endtask

  task automatic t_overflow();
    setreg(3, 8'hFF); setreg(4, 8'h01); setreg(2, 8'd23); setreg(1, 8'd59); setreg(0, 8'd59);
    pulses(DIV); snap();
    rd(3, "R6 day wrap", 8'h00);
    rd(4, "R6 overflow set", 8'hBE);
    pulses(DIV); snap();
    rd(4, "R6 overflow sticky", 8'hBE);
    setreg(4, 8'h00); snap();
    rd(4, "R6 overflow cleared", 8'h3E);
  endtask

  task automatic t_halt();
    setreg(4, 8'h40); setreg(0, 8'd20);
    pulses(3 * DIV); snap();
    rd(0, "R8 halted sec", 8'hD4);
    rd(4, "R8 halt bit", 8'h7E);
    setreg(4, 8'h00);
    pulses(DIV); snap();
    rd(0, "R8 resumed", 8'hD5);
  endtask

  task automatic t_latch();
    setreg(0, 8'd30); snap();
    rd(0, "R7 latched", 8'hDE);
    pulses(DIV);
    wr(16'h6000, 8'h01);
    rd(0, "R10 frozen while flag set", 8'hDE);
    wr(16'h7FFF, 8'h02);
    wr(16'h6000, 8'h00);
    rd(0, "R7 clear keeps snapshot", 8'hDE);
    wr(16'h6000, 8'h01);
    rd(0, "R7 relatch", 8'hDF);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_select();
    t_window_off();
    t_count();
    t_prescale_clear();
    t_day_chain();
    t_overflow();
    t_halt();
    t_latch();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule